// File: doc/BRIEF.md
# Block and Byte Transfer Sequencer

The sequencer sits between a 16-bit word buffer and a byte-wide card data channel. A transfer consists of a programmed number of blocks, and each block holds a programmed number of bytes. In the receive direction the block takes bytes from the card, pairs them into words and pushes the words into the buffer. In the transmit direction it reads the word at the buffer head, sends it as two bytes and pops the word.

Two nested down-counters track the transfer: one counts the bytes left in the current block and one counts the blocks left. Each reloads itself when it runs out. Both counters are visible at the ports at all times. When the last byte of the last block moves, the sequencer goes idle and sets a sticky done flag. The next accepted start clears that flag.

Receive traffic pauses while the buffer fill is above an almost-full threshold. Transmit traffic waits while the buffer is empty.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `byte_left` and `blk_left` are 0, `busy` and `done` are 0, and `crd_in_ready`, `crd_out_valid`, `buf_push` and `buf_pop` are all low.
- R2: A `len_wr` pulse loads the byte counter with `len_val` + 1. The value shows on `byte_left` at the next clock.
- R3: A `cnt_wr` pulse loads the block counter with `cnt_val` + 1. In the same cycle the byte counter reloads to the programmed block length. This also applies while a transfer is running.
- R4: `start` is ignored if either counter reads 0 or a transfer is already running. An ignored start leaves `busy` and the handshakes unchanged.
- R5: In receive mode, the first byte of a word lands in bits 7:0 and the second in bits 15:8. The word is pushed in the same cycle the second byte is accepted.
- R6: If the byte counter reaches zero on the first byte of a word, a word is pushed at once with bits 15:8 zero. The next card byte then starts a new word.
- R7: In transmit mode, bits 7:0 of the head word are sent first and bits 15:8 second. The word is popped with its second byte, or with its first byte when that byte ends the block, in which case bits 15:8 are never sent.
- R8: Every transferred byte lowers `byte_left` by one. When it would reach zero, `blk_left` drops by one and `byte_left` reloads to the programmed block length.
- R9: On the final byte of the final block, `blk_left` reloads to the programmed count, `busy` falls and `done` rises in the same cycle. `done` stays high until the next accepted start.
- R10: While `buf_fill` is greater than `af_level`, no new receive word is started: `crd_in_ready` is low at a word boundary and the counters hold.
- R11: In transmit mode, `crd_out_valid` stays low while `buf_fill` is 0, even when a transfer is running.
- R12: `buf_push` and `buf_pop` are never high together, and `buf_pop` is never high while `buf_fill` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| len_wr | input | 1 | Write strobe for block length |
| len_val | input | 11 | Block length minus one |
| cnt_wr | input | 1 | Write strobe for block count |
| cnt_val | input | 11 | Block count minus one |
| start | input | 1 | Start pulse |
| dir_rx | input | 1 | Direction sampled at start: 1 receive, 0 transmit |
| af_level | input | 5 | Almost-full threshold |
| buf_fill | input | 6 | Words held in the buffer |
| buf_push | output | 1 | Push a received word |
| buf_wdata | output | 16 | Word being pushed |
| buf_pop | output | 1 | Pop the head word |
| buf_rdata | input | 16 | Head word of the buffer |
| crd_in_valid | input | 1 | Card offers a byte |
| crd_in_data | input | 8 | Byte from the card |
| crd_in_ready | output | 1 | Sequencer accepts a card byte |
| crd_out_valid | output | 1 | Sequencer offers a byte to the card |
| crd_out_data | output | 8 | Byte to the card |
| crd_out_ready | input | 1 | Card accepts the byte |
| byte_left | output | 12 | Live byte counter |
| blk_left | output | 12 | Live block counter |
| busy | output | 1 | Transfer running |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
A half-word phase that goes out of step shows up on the first pushed or sent word: the bytes swap, or an odd-length block gets a stray upper byte, and the scoreboard catches it in that cycle. A byte counter that decrements or reloads wrongly shifts every later word boundary, and it is also visible directly on `byte_left` one clock after the handshake. A wrong block counter first shows at a block boundary, through `blk_left`, or as a `done` that rises one block early or late. A stuck pause condition shows as a handshake that never completes, and the watchdog ends the run.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/bxs_counters.sv
module bxs_counters #(
  parameter int LEN_W = 11,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             cnt_wr,
  input  logic [LEN_W-1:0] cnt_val,
  input  logic             step,
  output logic [CNT_W-1:0] byte_left,
  output logic [CNT_W-1:0] blk_left,
  output logic             byte_last,
  output logic             xfer_end
);
  logic [CNT_W-1:0] len_q, len_n;
  logic [CNT_W-1:0] num_q, num_n;
  logic [CNT_W-1:0] byte_q, byte_n;
  logic [CNT_W-1:0] blk_q, blk_n;
  logic             blk_end;
  logic             upd_en;
  logic [CNT_W-1:0] len_new, num_new;

  assign len_new   = {1'b0, len_val} + CNT_W'(1);
  assign num_new   = {1'b0, cnt_val} + CNT_W'(1);
  assign byte_last = (byte_q == CNT_W'(1));
  assign blk_end   = step & byte_last;
  assign xfer_end  = blk_end & (blk_q == CNT_W'(1));
  assign upd_en    = step | len_wr | cnt_wr;

  always_comb begin
    len_n  = len_q;
    num_n  = num_q;
    byte_n = byte_q;
    blk_n  = blk_q;
    if (step) begin
      if (blk_end) begin
        byte_n = len_q;
        blk_n  = xfer_end ? num_q : blk_q - CNT_W'(1);
      end else begin
        byte_n = byte_q - CNT_W'(1);
      end
    end
    if (len_wr) begin
      len_n  = len_new;
      byte_n = len_new;
    end
    if (cnt_wr) begin
      num_n  = num_new;
      blk_n  = num_new;
      byte_n = len_wr ? len_new : len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      num_q  <= '0;
      byte_q <= '0;
      blk_q  <= '0;
    end else if (upd_en) begin
      len_q  <= len_n;
      num_q  <= num_n;
      byte_q <= byte_n;
      blk_q  <= blk_n;
    end
  end

  assign byte_left = byte_q;
  assign blk_left  = blk_q;
endmodule

// File: rtl/bxs_rx_pack.sv
module bxs_rx_pack
  import bxs_pkg::*;
#(
  parameter int FILL_W = 6,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FILL_W-1:0] fill,
  input  logic [LVL_W-1:0]  af_lvl,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              byte_last,
  output logic              in_ready,
  output logic              step,
  output logic              push,
  output logic [WORD_W-1:0] push_data
);
  half_e             half_q, half_n;
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic              room;

  assign room      = (fill <= FILL_W'(af_lvl));
  assign in_ready  = en & ((half_q == HALF_HI) | room);
  assign step      = in_valid & in_ready;
  assign push      = step & ((half_q == HALF_HI) | byte_last);
  assign push_data = (half_q == HALF_HI) ? {in_data, lo_q} : {{BYTE_W{1'b0}}, in_data};

  always_comb begin
    half_n = half_q;
    lo_n   = lo_q;
    if (!en) begin
      half_n = HALF_LO;
    end else if (step) begin
      if (half_q == HALF_HI) begin
        half_n = HALF_LO;
      end else begin
        lo_n   = in_data;
        half_n = byte_last ? HALF_LO : HALF_HI;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_LO;
      lo_q   <= '0;
    end else begin
      half_q <= half_n;
      lo_q   <= lo_n;
    end
  end
endmodule

// File: rtl/bxs_tx_unpack.sv
module bxs_tx_unpack
  import bxs_pkg::*;
#(
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FILL_W-1:0] fill,
  input  logic [WORD_W-1:0] rdata,
  input  logic              out_ready,
  input  logic              byte_last,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              step,
  output logic              pop
);
  half_e half_q, half_n;

  assign out_valid = en & (fill != '0);
  assign out_data  = (half_q == HALF_HI) ? rdata[WORD_W-1:BYTE_W] : rdata[BYTE_W-1:0];
  assign step      = out_valid & out_ready;
  assign pop       = step & ((half_q == HALF_HI) | byte_last);

  always_comb begin
    half_n = half_q;
    if (!en) begin
      half_n = HALF_LO;
    end else if (step) begin
      if (half_q == HALF_HI) half_n = HALF_LO;
      else                   half_n = byte_last ? HALF_LO : HALF_HI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= HALF_LO;
    else        half_q <= half_n;
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int BUF_DEPTH = 32,
  localparam int CNT_W  = LEN_W + 1,
  localparam int FILL_W = $clog2(BUF_DEPTH + 1),
  localparam int LVL_W  = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              cnt_wr,
  input  logic [LEN_W-1:0]  cnt_val,
  input  logic              start,
  input  logic              dir_rx,
  input  logic [LVL_W-1:0]  af_level,
  input  logic [FILL_W-1:0] buf_fill,
  output logic              buf_push,
  output logic [WORD_W-1:0] buf_wdata,
  output logic              buf_pop,
  input  logic [WORD_W-1:0] buf_rdata,
  input  logic              crd_in_valid,
  input  logic [BYTE_W-1:0] crd_in_data,
  output logic              crd_in_ready,
  output logic              crd_out_valid,
  output logic [BYTE_W-1:0] crd_out_data,
  input  logic              crd_out_ready,
  output logic [CNT_W-1:0]  byte_left,
  output logic [CNT_W-1:0]  blk_left,
  output logic              busy,
  output logic              done
);
  logic      rst_s1_q, rst_s2_q, rst_int_n;
  logic      busy_q, busy_n;
  logic      done_q, done_n;
  xfer_dir_e dir_q, dir_n;
  logic      ctl_en;
  logic      start_ok;
  logic      rx_en, tx_en;
  logic      rx_step, tx_step, step;
  logic      byte_last, xfer_end;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  assign start_ok = start & ~busy_q & (byte_left != '0) & (blk_left != '0);
  assign rx_en    = busy_q & (dir_q == DIR_RX);
  assign tx_en    = busy_q & (dir_q == DIR_TX);
  assign step     = rx_step | tx_step;
  assign ctl_en   = start_ok | xfer_end;

  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    dir_n  = dir_q;
    if (start_ok) begin
      busy_n = 1'b1;
      done_n = 1'b0;
      dir_n  = dir_rx ? DIR_RX : DIR_TX;
    end else if (xfer_end) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_TX;
    end else if (ctl_en) begin
      busy_q <= busy_n;
      done_q <= done_n;
      dir_q  <= dir_n;
    end
  end

  bxs_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .len_wr    (len_wr),
    .len_val   (len_val),
    .cnt_wr    (cnt_wr),
    .cnt_val   (cnt_val),
    .step      (step),
    .byte_left (byte_left),
    .blk_left  (blk_left),
    .byte_last (byte_last),
    .xfer_end  (xfer_end)
  );

  bxs_rx_pack #(.FILL_W(FILL_W), .LVL_W(LVL_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (rx_en),
    .fill      (buf_fill),
    .af_lvl    (af_level),
    .in_valid  (crd_in_valid),
    .in_data   (crd_in_data),
    .byte_last (byte_last),
    .in_ready  (crd_in_ready),
    .step      (rx_step),
    .push      (buf_push),
    .push_data (buf_wdata)
  );

  bxs_tx_unpack #(.FILL_W(FILL_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (tx_en),
    .fill      (buf_fill),
    .rdata     (buf_rdata),
    .out_ready (crd_out_ready),
    .byte_last (byte_last),
    .out_valid (crd_out_valid),
    .out_data  (crd_out_data),
    .step      (tx_step),
    .pop       (buf_pop)
  );

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
  parameter int CNT_W  = 12,
  parameter int FILL_W = 6,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              len_wr,
  input logic              cnt_wr,
  input logic              crd_in_valid,
  input logic              crd_in_ready,
  input logic              crd_out_valid,
  input logic              crd_out_ready,
  input logic              buf_push,
  input logic              buf_pop,
  input logic [FILL_W-1:0] buf_fill,
  input logic [LVL_W-1:0]  af_level,
  input logic [CNT_W-1:0]  byte_left,
  input logic [CNT_W-1:0]  blk_left,
  input logic              busy,
  input logic              done
);
  logic moved;
  assign moved = (crd_in_valid & crd_in_ready) | (crd_out_valid & crd_out_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!crd_in_ready && !crd_out_valid && !buf_push && !buf_pop));

  // R8
  byte_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && !len_wr && !cnt_wr && byte_left > CNT_W'(1)) |=>
      (byte_left == $past(byte_left) - CNT_W'(1)));

  // R8
  blk_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && !len_wr && !cnt_wr && byte_left == CNT_W'(1) && blk_left > CNT_W'(1)) |=>
      (blk_left == $past(blk_left) - CNT_W'(1)));

  // R9
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R4
  busy_counts_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_left != '0 && blk_left != '0));

  // R10
  push_below_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_push |-> (buf_fill <= FILL_W'(af_level)));

  // R12
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_push, buf_pop}));

  // R12
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> (buf_fill != '0));
endmodule

bind blk_xfer_seq bxs_checker #(.CNT_W(CNT_W), .FILL_W(FILL_W), .LVL_W(LVL_W)) u_bxs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .len_wr        (len_wr),
  .cnt_wr        (cnt_wr),
  .crd_in_valid  (crd_in_valid),
  .crd_in_ready  (crd_in_ready),
  .crd_out_valid (crd_out_valid),
  .crd_out_ready (crd_out_ready),
  .buf_push      (buf_push),
  .buf_pop       (buf_pop),
  .buf_fill      (buf_fill),
  .af_level      (af_level),
  .byte_left     (byte_left),
  .blk_left      (blk_left),
  .busy          (busy),
  .done          (done)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 1'b0, cnt_wr = 1'b0, start = 1'b0, dir_rx = 1'b0;
  logic [10:0] len_val = '0, cnt_val = '0;
  logic [4:0]  af_level = 5'd31;
  logic [5:0]  buf_fill;
  logic        buf_push, buf_pop;
  logic [15:0] buf_wdata, buf_rdata;
  logic        crd_in_valid = 1'b0, crd_in_ready;
  logic [7:0]  crd_in_data = '0, crd_out_data;
  logic        crd_out_valid, crd_out_ready = 1'b0;
  logic [11:0] byte_left, blk_left;
  logic        busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .start(start), .dir_rx(dir_rx),
    .af_level(af_level), .buf_fill(buf_fill), .buf_push(buf_push),
    .buf_wdata(buf_wdata), .buf_pop(buf_pop), .buf_rdata(buf_rdata),
    .crd_in_valid(crd_in_valid), .crd_in_data(crd_in_data), .crd_in_ready(crd_in_ready),
    .crd_out_valid(crd_out_valid), .crd_out_data(crd_out_data), .crd_out_ready(crd_out_ready),
    .byte_left(byte_left), .blk_left(blk_left), .busy(busy), .done(done)
  );

  // buffer model
  int          rxwp = 0, rxrp = 0, txwp = 0, txrp = 0;
  logic [15:0] txmem [64];
  bit          mode_rx = 1'b1, flush = 1'b0, auto_drain = 1'b0;

  assign buf_fill  = mode_rx ? 6'(rxwp - rxrp) : 6'(txwp - txrp);
  assign buf_rdata = txmem[txrp % 64];

  always @(posedge clk) begin
    if (buf_push) rxwp <= rxwp + 1;
    if (flush) rxrp <= rxwp;
    else if (auto_drain && rxwp != rxrp) rxrp <= rxrp + 1;
    if (buf_pop) txrp <= txrp + 1;
  end

  int n_vec = 0, n_bad = 0, r12_viol = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [15:0] exp_words [$];
  logic [7:0]  exp_bytes [$];

  always @(negedge clk) begin
    logic [15:0] w;
    logic [7:0]  b;
    if (rst_n) begin
      if (buf_push && buf_pop) r12_viol++;
      if (buf_pop && buf_fill == 0) r12_viol++;
      if (buf_push) begin
        if (exp_words.size() == 0) chk(1'b0, "R5 unexpected push", buf_wdata, 0);
        else begin
          w = exp_words.pop_front();
          chk(buf_wdata == w, "R5/R6 pushed word", buf_wdata, w);
        end
      end
      if (crd_out_valid && crd_out_ready) begin
        if (exp_bytes.size() == 0) chk(1'b0, "R7 unexpected byte", crd_out_data, 0);
        else begin
          b = exp_bytes.pop_front();
          chk(crd_out_data == b, "R7 sent byte", crd_out_data, b);
        end
      end
    end
  end

  // receive-side reference model
  int          m_len = 0, m_rem = 0;
  bit          m_hi = 1'b0;
  logic [7:0]  m_lo = '0;

  task automatic wr_len(input int v);
    @(posedge clk); #2 len_wr = 1'b1; len_val = 11'(v);
    @(posedge clk); #2 len_wr = 1'b0;
    m_len = v + 1; m_rem = m_len;
  endtask

  task automatic wr_cnt(input int v);
    @(posedge clk); #2 cnt_wr = 1'b1; cnt_val = 11'(v);
    @(posedge clk); #2 cnt_wr = 1'b0;
    m_rem = m_len;
  endtask

  task automatic pulse_start(input bit d);
    @(posedge clk); #2 start = 1'b1; dir_rx = d;
    @(posedge clk); #2 start = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(posedge clk); #2 crd_in_valid = 1'b1; crd_in_data = b;
    if (!m_hi) begin
      if (m_rem == 1) exp_words.push_back({8'h00, b});
      else begin m_lo = b; m_hi = 1'b1; end
    end else begin
      exp_words.push_back({b, m_lo});
      m_hi = 1'b0;
    end
    m_rem--;
    if (m_rem == 0) m_rem = m_len;
    do @(negedge clk); while (!crd_in_ready);
  endtask

  task automatic end_rx;
    @(posedge clk); #2 crd_in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_tx(input logic [15:0] w);
    @(posedge clk); #2 txmem[txwp % 64] = w; txwp++;
  endtask

  task automatic run_tx;
    int k = 0;
    while (1) begin
      @(posedge clk); #2 crd_out_ready = (k % 3) != 2;
      k++;
      @(negedge clk);
      if (!busy) break;
    end
    crd_out_ready = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(byte_left == 0 && blk_left == 0, "R1 counters", {byte_left, blk_left}, 0);
    chk(!busy && !done, "R1 status", {busy, done}, 0);
    chk(!crd_in_ready && !crd_out_valid && !buf_push && !buf_pop, "R1 handshakes",
        {crd_in_ready, crd_out_valid, buf_push, buf_pop}, 0);

    // R4 start with zero counters
    pulse_start(1'b1);
    chk(!busy && !crd_in_ready, "R4 start with zero counts", {busy, crd_in_ready}, 0);

    // R2 / R3 programming and reload during a transfer
    wr_len(3);
    @(negedge clk);
    chk(byte_left == 4, "R2 length load", byte_left, 4);
    wr_cnt(0);
    @(negedge clk);
    chk(blk_left == 1 && byte_left == 4, "R3 count load", {blk_left, byte_left}, {12'd1, 12'd4});
    pulse_start(1'b1);
    send_rx(8'h10);
    end_rx();
    chk(byte_left == 3, "R8 byte decrement", byte_left, 3);
    wr_cnt(0);
    @(negedge clk);
    chk(byte_left == 4 && blk_left == 1, "R3 reload mid transfer", byte_left, 4);
    send_rx(8'h20); send_rx(8'h30); send_rx(8'h40); send_rx(8'h50);
    end_rx();
    chk(!busy && done, "R9 end after reload", {busy, done}, 1);

    // R5 / R6 / R8 odd blocks, two of them
    wr_len(2);
    wr_cnt(1);
    pulse_start(1'b1);
    chk(busy && !done, "R9 done cleared by start", {busy, done}, 2);
    send_rx(8'hA1); send_rx(8'hB2); send_rx(8'hC3);
    end_rx();
    chk(blk_left == 1 && byte_left == 3, "R8 block step and reload", {blk_left, byte_left}, {12'd1, 12'd3});
    send_rx(8'hD4); send_rx(8'hE5); send_rx(8'hF6);
    end_rx();
    chk(!busy && done && blk_left == 2 && byte_left == 3, "R9 final reload",
        {busy, done, blk_left, byte_left}, {2'b01, 12'd2, 12'd3});

    // R10 pause above almost-full level
    flush = 1'b1; @(posedge clk); #2 flush = 1'b0;
    af_level = 5'd1;
    wr_len(9);
    wr_cnt(0);
    pulse_start(1'b1);
    send_rx(8'h01); send_rx(8'h02); send_rx(8'h03); send_rx(8'h04);
    end_rx();
    chk(!crd_in_ready && busy, "R10 paused", crd_in_ready, 0);
    crd_in_valid = 1'b1; crd_in_data = 8'hFF;
    repeat (3) @(negedge clk);
    chk(!crd_in_ready && byte_left == 6 && !buf_push, "R10 held while full", byte_left, 6);
    crd_in_valid = 1'b0;
    auto_drain = 1'b1;
    send_rx(8'h05); send_rx(8'h06); send_rx(8'h07); send_rx(8'h08);
    send_rx(8'h09); send_rx(8'h0A);
    end_rx();
    chk(!busy && done, "R10 resumed and finished", {busy, done}, 1);
    chk(exp_words.size() == 0, "R5 all words seen", exp_words.size(), 0);
    auto_drain = 1'b0;

    // R11 / R4 / R7 transmit
    mode_rx = 1'b0;
    wr_len(4);
    wr_cnt(0);
    pulse_start(1'b0);
    chk(busy && !done, "R9 done cleared on transmit start", {busy, done}, 2);
    crd_out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!crd_out_valid && byte_left == 5, "R11 wait on empty buffer", crd_out_valid, 0);
    crd_out_ready = 1'b0;
    pulse_start(1'b1);
    chk(busy && !crd_in_ready, "R4 start ignored while busy", crd_in_ready, 0);
    exp_bytes.push_back(8'h11); exp_bytes.push_back(8'h22);
    exp_bytes.push_back(8'h33); exp_bytes.push_back(8'h44);
    exp_bytes.push_back(8'h55);
    load_tx(16'h2211); load_tx(16'h4433); load_tx(16'hEE55);
    run_tx();
    chk(txrp == 3, "R7 words popped", txrp, 3);
    chk(exp_bytes.size() == 0, "R7 all bytes sent", exp_bytes.size(), 0);
    chk(done && byte_left == 5 && blk_left == 1, "R9 transmit end", {done, byte_left}, {1'b1, 12'd5});

    chk(r12_viol == 0, "R12 push/pop exclusive", r12_viol, 0);
    summary();
    $finish;
  end
endmodule